// File: doc/BRIEF.md
# SD Host Command Path

This block is the command half of an SD host controller. Software first loads a 32-bit argument and then writes a 16-bit command word. The block sends a 48-bit command frame out on the CMD line, one bit for each SD clock tick. The ticks are given to it as a single-cycle enable. After the frame it waits for the card's reply, checks it and stores it in four 32-bit response words. It raises a completion bit or a timeout bit, together with error bits for CRC and index mismatches.

Two inhibit flags in the present-state word tell software when a new command may be issued. CMD inhibit covers the whole command and its response. DAT inhibit covers commands that use the data lines: those that announce a data transfer and those whose card signals busy on DAT0. DAT inhibit is held until DAT0 is seen high. Data transfer and SD clock generation belong to other blocks. Here DAT[3:0] is only an input.

Long (136-bit) responses are stored with the trailing CRC and end bit removed, so the content sits 8 bits lower in the words. Software shifts each word left by 8 to rebuild the full register image.

Top module: `sdcmd_host`

## Requirements
- R1: A command write (`cmd_we`) is accepted only while CMD inhibit (present bit 0) is clear. Acceptance sets CMD inhibit on the next clock. A command write while CMD inhibit is set is ignored: no second frame goes out and nothing latched for the running command changes.
- R2: The frame is sent MSB first, one bit per `sd_ce` tick. It consists of a 0 start bit, a 1 transmission bit, the index from command bits [13:8], the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, seeded with zero, over the first 40 bits) and a 1 end bit. `cmd_line_oe` is high only while the frame is being sent, and `cmd_line_out` is 1 whenever it is not driven.
- R3: The argument is taken at the moment the command is accepted. Argument writes during a running command do not change the frame in flight.
- R4: Command bits [1:0] select the response: 00 none, 01 136-bit, 10 48-bit, 11 48-bit with busy. With 00, completion (status bit 0) is set right after the end bit and CMD inhibit clears at the same time.
- R5: For a 48-bit response, the 32 bits that follow the 6-bit index are stored in response word 0. Words 1 to 3 keep their value.
- R6: For a 136-bit response, the CRC7 and the end bit are removed. The 120 content bits are stored right-aligned: word 3 bits [23:0] get the most significant content bits, word 0 gets the least significant, and word 3 bits [31:24] are 0.
- R7: Waiting starts at the first tick after the end bit. If no start bit (0) is seen on `cmd_line_in` within 64 ticks, status bit 1 (timeout) is set, completion is not set and the response words keep their value. A start bit on the 64th tick is still accepted.
- R8: When CRC checking (command bit 3) is set and the received CRC7 does not match, status bit 2 is set. For 48-bit responses the CRC covers the 40 bits before it. For 136-bit responses it covers the 120 content bits. With bit 3 clear, a CRC mismatch sets nothing.
- R9: When index checking (command bit 4) is set and the index field of a 48-bit response differs from the command's index, status bit 3 is set. 136-bit responses are never index-checked.
- R10: The present-state word shows CMD inhibit in bit 0, DAT inhibit in bit 1 and `dat_in[3:0]` in bits [23:20]. All other bits read 0.
- R11: DAT inhibit is set when a command with response type 11 or data-present (command bit 5) is accepted. It clears at the first tick after the command has ended on which DAT0 is high. It stays set while DAT0 is low.
- R12: Status bits [3:0] are write-1-to-clear through `sts_clr_we`/`sts_clr`. A bit being set wins over a clear in the same cycle. Bit 4 is the OR of bits 1 to 3 and follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sd_ce | input | 1 | One-cycle SD clock tick |
| arg_we | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument value |
| cmd_we | input | 1 | Command write strobe (issues the command) |
| cmd_wdata | input | 16 | Command word |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr | input | 4 | Write-1-to-clear mask for status bits [3:0] |
| int_sts | output | 5 | Status: complete, timeout, CRC error, index error, error summary |
| present | output | 32 | Present-state word |
| rsp0 | output | 32 | Response word 0 |
| rsp1 | output | 32 | Response word 1 |
| rsp2 | output | 32 | Response word 2 |
| rsp3 | output | 32 | Response word 3 |
| cmd_line_out | output | 1 | CMD line value driven by the host |
| cmd_line_oe | output | 1 | CMD line drive enable |
| cmd_line_in | input | 1 | CMD line value seen from the card |
| dat_in | input | 4 | DAT[3:0] line levels |

## Verification
A status bit can be set by the command engine in the same cycle as software writes a one to clear it. The bench holds the clear strobe with a full mask for the whole of a command without a response, so the completion set must coincide with an active clear. It then judges two things: the completion bit is seen high for at least a cycle, which shows the set won, and the bit reads zero afterwards, which shows the held clear took effect. A second case collides a command write with a command already in flight: the bench checks that exactly one frame, with the first index and argument, is sent.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int SD_ARG_W = 32;
    localparam int SD_IDX_W = 6;
    localparam int SD_CRC_W = 7;
    localparam logic [SD_CRC_W-1:0] SD_CRC_POLY = 7'h09;

    typedef enum logic [1:0] {
        RSP_NONE = 2'b00,
        RSP_LONG = 2'b01,
        RSP_SHORT = 2'b10,
        RSP_SHORT_BUSY = 2'b11
    } rsp_kind_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_WAIT,
        RX_RECV
    } rx_phase_e;

    // One serial step of the CRC7 used on the command line.
    function automatic logic [SD_CRC_W-1:0] crc7_next(input logic [SD_CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[SD_CRC_W-1];
        return {c[SD_CRC_W-2:0], 1'b0} ^ (fb ? SD_CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
    import sdcmd_pkg::*;
#(
    parameter int IDX_W = SD_IDX_W,
    parameter int ARG_W = SD_ARG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             start,
    input  logic [IDX_W-1:0] idx,
    input  logic [ARG_W-1:0] arg,
    output logic             line,
    output logic             busy,
    output logic             done
);
    localparam int BODY_W  = 2 + IDX_W + ARG_W;
    localparam int FRAME_W = BODY_W + SD_CRC_W + 1;
    localparam int NW      = $clog2(FRAME_W);
    localparam logic [NW-1:0] BODY_END = NW'(BODY_W);
    localparam logic [NW-1:0] LAST     = NW'(FRAME_W - 1);

    typedef struct packed {
        logic                busy;
        logic [NW-1:0]       n;
        logic [BODY_W-1:0]   sh;
        logic [SD_CRC_W-1:0] crc;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.busy = 1'b1;
            d.n    = '0;
            d.sh   = {2'b01, idx, arg};
            d.crc  = '0;
        end else if (q.busy && ce) begin
            if (q.n < BODY_END) begin
                d.crc = crc7_next(q.crc, q.sh[BODY_W-1]);
                d.sh  = q.sh << 1;
            end else if (q.n < LAST) begin
                d.crc = q.crc << 1;
            end else begin
                d.busy = 1'b0;
            end
            d.n = q.n + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = q.busy;
    assign done = q.busy && ce && (q.n == LAST);
    assign line = !q.busy          ? 1'b1 :
                  (q.n < BODY_END) ? q.sh[BODY_W-1] :
                  (q.n < LAST)     ? q.crc[SD_CRC_W-1] : 1'b1;

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
    import sdcmd_pkg::*;
#(
    parameter int TIMEOUT = 64,
    parameter int LONG_W  = 136,
    parameter int SHORT_W = 48,
    parameter int SKIP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              start,
    input  logic              long_rsp,
    input  logic              line_in,
    output logic              rsp_done,
    output logic              rsp_timeout,
    output logic              crc_ok,
    output logic [LONG_W-1:0] frame
);
    localparam int NW = $clog2(LONG_W);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam int TAIL_W = SD_CRC_W + 1;
    localparam logic [NW-1:0] LAST_LONG  = NW'(LONG_W - 1);
    localparam logic [NW-1:0] LAST_SHORT = NW'(SHORT_W - 1);
    localparam logic [NW-1:0] LONG_LO    = NW'(SKIP_W);
    localparam logic [NW-1:0] LONG_HI    = NW'(LONG_W - TAIL_W);
    localparam logic [NW-1:0] SHORT_HI   = NW'(SHORT_W - TAIL_W);
    localparam logic [TW-1:0] T_LAST     = TW'(TIMEOUT - 1);

    typedef struct packed {
        rx_phase_e           phase;
        logic [TW-1:0]       tcnt;
        logic [NW-1:0]       n;
        logic                long_f;
        logic [LONG_W-1:0]   sh;
        logic [SD_CRC_W-1:0] crc;
        logic                done;
        logic                tmo;
    } rx_st_t;

    rx_st_t q, d;
    logic   covered;

    always_comb begin
        covered = q.long_f ? (q.n >= LONG_LO && q.n < LONG_HI) : (q.n < SHORT_HI);
        d      = q;
        d.done = 1'b0;
        d.tmo  = 1'b0;
        if (start) begin
            d.phase  = RX_WAIT;
            d.tcnt   = '0;
            d.long_f = long_rsp;
            d.sh     = '0;
            d.crc    = '0;
        end else if (ce) begin
            case (q.phase)
                RX_WAIT: begin
                    if (!line_in) begin
                        d.phase = RX_RECV;
                        d.n     = NW'(1);
                        d.sh    = {q.sh[LONG_W-2:0], 1'b0};
                        d.crc   = q.long_f ? q.crc : crc7_next(q.crc, 1'b0);
                    end else if (q.tcnt == T_LAST) begin
                        d.phase = RX_IDLE;
                        d.tmo   = 1'b1;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                RX_RECV: begin
                    d.sh = {q.sh[LONG_W-2:0], line_in};
                    if (covered) d.crc = crc7_next(q.crc, line_in);
                    if (q.n == (q.long_f ? LAST_LONG : LAST_SHORT)) begin
                        d.phase = RX_IDLE;
                        d.done  = 1'b1;
                    end
                    d.n = q.n + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: RX_IDLE, default: '0};
        else        q <= d;
    end

    assign rsp_done    = q.done;
    assign rsp_timeout = q.tmo;
    assign frame       = q.sh;
    assign crc_ok      = (q.crc == q.sh[SD_CRC_W:1]);

endmodule

// File: rtl/sdcmd_host.sv
module sdcmd_host
    import sdcmd_pkg::*;
#(
    parameter int RSP_TIMEOUT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sd_ce,
    input  logic        arg_we,
    input  logic [31:0] arg_wdata,
    input  logic        cmd_we,
    input  logic [15:0] cmd_wdata,
    input  logic        sts_clr_we,
    input  logic [3:0]  sts_clr,
    output logic [4:0]  int_sts,
    output logic [31:0] present,
    output logic [31:0] rsp0,
    output logic [31:0] rsp1,
    output logic [31:0] rsp2,
    output logic [31:0] rsp3,
    output logic        cmd_line_out,
    output logic        cmd_line_oe,
    input  logic        cmd_line_in,
    input  logic [3:0]  dat_in
);
    localparam int LONG_W  = 136;
    localparam int SHORT_W = 48;
    localparam int WORDS   = 4;
    localparam int WORD_W  = SD_ARG_W;
    localparam int CUT_W   = SD_CRC_W + 1;
    localparam int TOP_W   = LONG_W - 2 - SD_IDX_W - CUT_W - (WORDS - 1) * WORD_W;
    localparam int IDX_LO  = SHORT_W - 2 - SD_IDX_W;

    typedef struct packed {
        logic [SD_ARG_W-1:0]          arg;
        logic [SD_IDX_W-1:0]          idx;
        rsp_kind_e                    kind;
        logic                         idx_chk;
        logic                         crc_chk;
        logic                         inh_cmd;
        logic                         inh_dat;
        logic [3:0]                   sts;
        logic [WORDS-1:0][WORD_W-1:0] rsp;
    } host_st_t;

    host_st_t q, d;

    logic              tx_start, tx_line, tx_busy, tx_done;
    logic              rx_start, rx_done, rx_tmo, rx_crc_ok;
    logic [LONG_W-1:0] rx_frame;
    logic              unused_bits;

    assign tx_start = cmd_we && !q.inh_cmd;
    assign rx_start = tx_done && (q.kind != RSP_NONE);
    assign unused_bits = ^{cmd_wdata[15:14], cmd_wdata[7:6], cmd_wdata[2],
                           rx_frame[LONG_W-1:LONG_W-2-SD_IDX_W], rx_frame[CUT_W-1:0]};

    sdcmd_tx #(.IDX_W(SD_IDX_W), .ARG_W(SD_ARG_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .ce(sd_ce), .start(tx_start),
        .idx(cmd_wdata[13:8]), .arg(q.arg),
        .line(tx_line), .busy(tx_busy), .done(tx_done)
    );

    sdcmd_rx #(.TIMEOUT(RSP_TIMEOUT), .LONG_W(LONG_W), .SHORT_W(SHORT_W), .SKIP_W(2 + SD_IDX_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .ce(sd_ce), .start(rx_start),
        .long_rsp(q.kind == RSP_LONG), .line_in(cmd_line_in),
        .rsp_done(rx_done), .rsp_timeout(rx_tmo), .crc_ok(rx_crc_ok), .frame(rx_frame)
    );

    always_comb begin
        d = q;
        if (arg_we) d.arg = arg_wdata;
        if (sts_clr_we) d.sts = q.sts & ~sts_clr;
        if (tx_start) begin
            d.idx     = cmd_wdata[13:8];
            d.kind    = rsp_kind_e'(cmd_wdata[1:0]);
            d.idx_chk = cmd_wdata[4];
            d.crc_chk = cmd_wdata[3];
            d.inh_cmd = 1'b1;
            if (cmd_wdata[5] || (cmd_wdata[1:0] == RSP_SHORT_BUSY)) d.inh_dat = 1'b1;
        end else if (q.inh_dat && !q.inh_cmd && sd_ce && dat_in[0]) begin
            d.inh_dat = 1'b0;
        end
        if (tx_done && (q.kind == RSP_NONE)) begin
            d.sts[0]  = 1'b1;
            d.inh_cmd = 1'b0;
        end
        if (rx_tmo) begin
            d.sts[1]  = 1'b1;
            d.inh_cmd = 1'b0;
        end
        if (rx_done) begin
            d.sts[0]  = 1'b1;
            d.inh_cmd = 1'b0;
            if (q.crc_chk && !rx_crc_ok) d.sts[2] = 1'b1;
            if (q.idx_chk && (q.kind != RSP_LONG) &&
                (rx_frame[IDX_LO +: SD_IDX_W] != q.idx)) d.sts[3] = 1'b1;
            if (q.kind == RSP_LONG) begin
                for (int k = 0; k < WORDS - 1; k++)
                    d.rsp[k] = rx_frame[CUT_W + k * WORD_W +: WORD_W];
                d.rsp[WORDS-1] = {{(WORD_W - TOP_W){1'b0}},
                                  rx_frame[CUT_W + (WORDS - 1) * WORD_W +: TOP_W]};
            end else begin
                d.rsp[0] = rx_frame[CUT_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{kind: RSP_NONE, default: '0};
        else        q <= d;
    end

    assign int_sts      = {|q.sts[3:1], q.sts};
    assign present      = {8'h00, dat_in, 18'h0, q.inh_dat, q.inh_cmd};
    assign rsp0         = q.rsp[0];
    assign rsp1         = q.rsp[1];
    assign rsp2         = q.rsp[2];
    assign rsp3         = q.rsp[3];
    assign cmd_line_out = tx_line;
    assign cmd_line_oe  = tx_busy;

endmodule

module sdcmd_host_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sd_ce,
    input logic        cmd_we,
    input logic        cmd_line_out,
    input logic        cmd_line_oe,
    input logic [3:0]  dat_in,
    input logic [31:0] present,
    input logic [4:0]  int_sts
);
    AST_OE_UNDER_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_line_oe |-> present[0]); // R1
    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_line_oe |-> cmd_line_out); // R2
    AST_BIT_HELD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_line_oe && $past(cmd_line_oe) && !$past(sd_ce)) |-> $stable(cmd_line_out)); // R2
    AST_ISSUE_SETS_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !present[0]) |=> present[0]); // R1
    AST_TIMEOUT_ENDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_sts[1]) |-> $fell(present[0])); // R7
    AST_COMPLETE_ENDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_sts[0]) |-> $fell(present[0])); // R4
    AST_DAT_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (present[1] && !dat_in[0]) |=> present[1]); // R11
endmodule

bind sdcmd_host sdcmd_host_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sd_ce(sd_ce), .cmd_we(cmd_we),
    .cmd_line_out(cmd_line_out), .cmd_line_oe(cmd_line_oe),
    .dat_in(dat_in), .present(present), .int_sts(int_sts)
);

// File: tb/sdcmd_host_tb_top.sv
`timescale 1ns/1ps
module sdcmd_host_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sd_ce = 1'b0;
    logic        arg_we = 1'b0;
    logic [31:0] arg_wdata = '0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        sts_clr_we = 1'b0;
    logic [3:0]  sts_clr = '0;
    logic [4:0]  int_sts;
    logic [31:0] present;
    logic [31:0] rsp0, rsp1, rsp2, rsp3;
    logic        cmd_line_out, cmd_line_oe;
    logic        cmd_line_in = 1'b1;
    logic [3:0]  dat_in = 4'hF;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sdcmd_host dut_i (
        .clk(clk), .rst_n(rst_n), .sd_ce(sd_ce), .arg_we(arg_we), .arg_wdata(arg_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .sts_clr_we(sts_clr_we), .sts_clr(sts_clr),
        .int_sts(int_sts), .present(present), .rsp0(rsp0), .rsp1(rsp1), .rsp2(rsp2), .rsp3(rsp3),
        .cmd_line_out(cmd_line_out), .cmd_line_oe(cmd_line_oe), .cmd_line_in(cmd_line_in),
        .dat_in(dat_in)
    );

    // Tick generator, card model and host-frame capture, all at the falling edge.
    int           div = 0;
    bit           card_arm = 0;
    logic [135:0] card_frame;
    int           card_len = 0, card_wait = 0, card_idx = 0;
    logic [47:0]  host_frame = '0;
    int           host_n = 0;

    always @(negedge clk) begin
        div = (div == 2) ? 0 : div + 1;
        sd_ce = (div == 0);
        if (sd_ce) begin
            if (card_arm && host_n >= 48) begin
                if (card_wait > 0) begin
                    card_wait--;
                    cmd_line_in = 1'b1;
                end else if (card_idx < card_len) begin
                    cmd_line_in = card_frame[card_len-1-card_idx];
                    card_idx++;
                end else begin
                    cmd_line_in = 1'b1;
                    card_arm = 0;
                end
            end
            if (cmd_line_oe) begin
                host_frame = {host_frame[46:0], cmd_line_out};
                host_n++;
            end
        end
    end

    function automatic logic [6:0] crc7(input logic [119:0] v, input int len);
        logic [6:0] c = '0;
        for (int i = len - 1; i >= 0; i--) begin
            logic fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [47:0] host_expect(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] body = {2'b01, idx, arg};
        return {body, crc7({80'h0, body}, 40), 1'b1};
    endfunction

    function automatic logic [119:0] long_content(input logic [31:0] s);
        return {s[23:0], ~s, s ^ 32'h5A5A_0F0F, s + 32'd1};
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_sts(input logic [3:0] m);
        @(negedge clk); sts_clr_we = 1'b1; sts_clr = m;
        @(negedge clk); sts_clr_we = 1'b0; sts_clr = '0;
    endtask

    task automatic write_arg(input logic [31:0] a);
        @(negedge clk); arg_we = 1'b1; arg_wdata = a;
        @(negedge clk); arg_we = 1'b0;
    endtask

    task automatic write_cmd(input logic [5:0] idx, input logic [5:0] flags);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = {2'b00, idx, 2'b00, flags};
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic arm_card(input logic [5:0] idx, input logic [1:0] rt, input logic [2:0] fault,
                            input int delay, input logic [31:0] seed);
        logic [6:0] c;
        if (rt == 2'b01) begin
            c = crc7(long_content(seed), 120) ^ {6'b0, fault[0]};
            card_frame = {2'b00, 6'h3F, long_content(seed), c, 1'b1};
            card_len = 136;
        end else begin
            logic [39:0] b = {2'b00, idx ^ {5'b0, fault[1]}, seed};
            c = crc7({80'h0, b}, 40) ^ {6'b0, fault[0]};
            card_frame = {88'h0, b, c, 1'b1};
            card_len = 48;
        end
        card_wait = delay;
        card_idx = 0;
        card_arm = 1;
    endtask

    task automatic wait_done();
        int k = 0;
        while (!(int_sts[0] | int_sts[1]) && k < 3000) begin @(negedge clk); k++; end
    endtask

    task automatic wait_quiet();
        int k = 0;
        while ((card_arm || present[1:0] != 2'b00) && k < 3000) begin @(negedge clk); k++; end
        repeat (6) @(negedge clk);
    endtask

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [5:0]  flags;   // [5] data present, [4] index check, [3] CRC check, [1:0] response type
        logic [2:0]  fault;   // [0] bad CRC, [1] bad index, [2] card silent
        logic [7:0]  delay;
        logic [31:0] seed;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        {6'd0,  32'h0000_0000, 6'b000000, 3'b000, 8'd0,  32'h0000_0000},
        {6'd17, 32'h0000_1000, 6'b011010, 3'b000, 8'd2,  32'h0000_0900},
        {6'd2,  32'h0000_0000, 6'b001001, 3'b000, 8'd5,  32'h1234_5678},
        {6'd8,  32'h0000_01AA, 6'b011010, 3'b001, 8'd0,  32'h0000_01AA},
        {6'd13, 32'hABCD_0000, 6'b010010, 3'b011, 8'd1,  32'h00C0_FFEE},
        {6'd55, 32'hFFFF_FFFF, 6'b011010, 3'b000, 8'd63, 32'hDEAD_BEEF},
        {6'd9,  32'h5555_AAAA, 6'b001010, 3'b000, 8'd64, 32'h1111_1111},
        {6'd41, 32'h0F0F_0F0F, 6'b000010, 3'b100, 8'd0,  32'h0000_0000},
        {6'd3,  32'h0000_0000, 6'b011001, 3'b010, 8'd3,  32'hCAFE_0123},
        {6'd12, 32'h8000_0001, 6'b011011, 3'b000, 8'd1,  32'h0000_0C00},
        {6'd18, 32'h0000_0200, 6'b111010, 3'b000, 8'd4,  32'h0000_0900}
    };

    logic [31:0] exp_rsp [4] = '{32'h0, 32'h0, 32'h0, 32'h0};

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Reset state
        check(int_sts == 5'h00, "R12 reset status", int_sts, 5'h00);
        check(present == 32'h00F0_0000, "R10 reset present", present, 32'h00F0_0000);
        check({rsp3, rsp2, rsp1, rsp0} == '0, "R5 reset response", {rsp3, rsp2, rsp1, rsp0}, 0);
        check(cmd_line_out && !cmd_line_oe, "R2 idle line", {cmd_line_oe, cmd_line_out}, 2'b01);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            logic [1:0] rt = t.flags[1:0];
            logic [4:0] es;
            bit got;
            clear_sts(4'hF);
            write_arg(t.arg);
            host_n = 0;
            got = (rt != 2'b00) && !t.fault[2] && (t.delay < 64);
            if (rt != 2'b00 && !t.fault[2]) arm_card(t.idx, rt, t.fault, int'(t.delay), t.seed);
            write_cmd(t.idx, t.flags);
            wait_done();
            if (rt == 2'b00) es = 5'b00001;
            else if (!got) es = 5'b10010;
            else begin
                logic c = t.flags[3] && t.fault[0];
                logic i = t.flags[4] && t.fault[1] && (rt != 2'b01);
                es = {c | i, i, c, 1'b0, 1'b1};
            end
            if (got) begin
                if (rt == 2'b01) begin
                    logic [119:0] lc = long_content(t.seed);
                    exp_rsp[3] = {8'h00, lc[119:96]};
                    exp_rsp[2] = lc[95:64];
                    exp_rsp[1] = lc[63:32];
                    exp_rsp[0] = lc[31:0];
                end else begin
                    exp_rsp[0] = t.seed;
                end
            end
            @(negedge clk);
            check(int_sts == es, "R4 R7 R8 R9 R12 status", int_sts, es);
            check(host_n == 48 && host_frame == host_expect(t.idx, t.arg), "R2 frame", host_frame,
                  host_expect(t.idx, t.arg));
            check(present[0] == 1'b0, "R1 inhibit released", present, 0);
            check(rsp0 == exp_rsp[0], "R5 response word 0", rsp0, exp_rsp[0]);
            check({rsp3, rsp2, rsp1} == {exp_rsp[3], exp_rsp[2], exp_rsp[1]}, "R6 response words 3-1",
                  {rsp3, rsp2, rsp1}, {exp_rsp[3], exp_rsp[2], exp_rsp[1]});
            if (v == 0) check(host_frame == 48'h40_0000_0000_95, "R2 known frame", host_frame, 48'h40_0000_0000_95);
            wait_quiet();
            check(present[1] == 1'b0, "R11 DAT inhibit released", present, 0);
        end

        // R1 / R3: second command and argument write while busy
        clear_sts(4'hF);
        write_arg(32'h0A0B_0C0D);
        host_n = 0;
        arm_card(6'd7, 2'b10, 3'b000, 20, 32'h7777_0007);
        write_cmd(6'd7, 6'b000010);
        repeat (10) @(negedge clk);
        write_arg(32'hFFFF_0000);
        write_cmd(6'd33, 6'b000000);
        wait_done();
        @(negedge clk);
        check(host_frame == host_expect(6'd7, 32'h0A0B_0C0D), "R3 argument held in flight", host_frame,
              host_expect(6'd7, 32'h0A0B_0C0D));
        check(int_sts == 5'b00001 && rsp0 == 32'h7777_0007, "R1 first command intact", {int_sts, rsp0},
              {5'b00001, 32'h7777_0007});
        repeat (400) @(negedge clk);
        check(host_n == 48 && present[0] == 1'b0, "R1 ignored write sends nothing", host_n, 48);

        // R11 / R10: busy response with DAT0 low
        clear_sts(4'hF);
        dat_in = 4'b1110;
        host_n = 0;
        arm_card(6'd6, 2'b11, 3'b000, 1, 32'h0000_0600);
        write_cmd(6'd6, 6'b000011);
        wait_done();
        @(negedge clk);
        check(present == 32'h00E0_0002, "R10 R11 busy present", present, 32'h00E0_0002);
        repeat (60) @(negedge clk);
        check(present[1] == 1'b1, "R11 held while DAT0 low", present, 32'h2);
        dat_in = 4'hF;
        repeat (8) @(negedge clk);
        check(present[1] == 1'b0, "R11 released on DAT0 high", present, 0);
        wait_quiet();

        // R12: set wins over a clear held through the whole command
        clear_sts(4'hF);
        host_n = 0;
        begin
            bit seen = 0;
            @(negedge clk); sts_clr_we = 1'b1; sts_clr = 4'hF;
            write_cmd(6'd0, 6'b000000);
            for (int k = 0; k < 600; k++) begin
                @(negedge clk);
                if (int_sts[0]) seen = 1;
            end
            check(seen, "R12 set wins over clear", seen, 1);
            check(int_sts == 5'h00, "R12 held clear takes effect", int_sts, 5'h00);
            sts_clr_we = 1'b0; sts_clr = '0;
        end

        // R12 / R7: partial write-1-to-clear after a timeout
        clear_sts(4'hF);
        host_n = 0;
        write_cmd(6'd5, 6'b000010);
        wait_done();
        @(negedge clk);
        check(int_sts == 5'b10010, "R7 silent card timeout", int_sts, 5'b10010);
        clear_sts(4'b0001);
        check(int_sts == 5'b10010, "R12 clear of other bit", int_sts, 5'b10010);
        clear_sts(4'b0010);
        check(int_sts == 5'b00000, "R12 clear timeout and summary", int_sts, 5'b00000);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule